// File: doc/BRIEF.md
# Accumulating Burst Conversion Sequencer

This block drives one logical channel of an analog-to-digital converter that turns a single trigger into a burst of back-to-back conversions. It asks a conversion engine for one sample at a time and adds each 12-bit result into a 16-bit running sum. When the last sample of the burst has been added, it raises a done flag and presents the finished sum. The burst length comes from a 4-bit count field. The count field holds the number of conversions minus one, so a value of zero gives an ordinary single conversion.

A higher-priority request can take the engine away from the channel. A forced-stop setting and a per-channel "not interruptible" setting decide whether the request may cut a conversion short, may only wait for the next gap between samples, or must wait for the whole burst to finish. While the higher-priority work runs, the channel waits. When the request goes away, a policy setting tells the channel to continue the remaining conversions, start the burst over, or abandon it. Every preemption sets a sticky interrupted flag.

The engine handshake works as follows. `conv_req_o` stays high while the channel wants a sample. The engine answers with a one-cycle `conv_ack_i` that carries the data. If the request drops before the acknowledge arrives, the conversion in flight is cancelled.

Top module: `mcacc_seq`

## Requirements
- R1: One trigger performs exactly `cfg_count_i`+1 acknowledged conversions, from 1 to 16.
- R2: With `cfg_count_i` = 0 the channel completes after a single acknowledged conversion.
- R3: `sum_o` equals the unsigned sum of all samples accepted in the burst, with no overflow at 16 × 4095. `done_o` and the final `sum_o` become visible at the same clock edge that takes in the last acknowledge.
- R4: With `cfg_force_stop_i`=0 and `cfg_no_intra_i`=1, a pending higher-priority request does not stop the burst, and `intr_o` is not set.
- R5: With `cfg_force_stop_i`=0 and `cfg_no_intra_i`=0, a pending request never cuts a conversion short. It yields only at an acknowledge that leaves conversions remaining: the sample is kept, `conv_req_o` falls at that edge, and no new conversion starts while the request stays pending.
- R6: With `cfg_force_stop_i`=1, a pending request during a conversion drops `conv_req_o` at the next edge. The cancelled sample is neither summed nor counted.
- R7: Every preemption sets `intr_o`. It stays set until `irq_clr_i`, and a new preemption in the same cycle as a clear wins.
- R8: When `hp_pend_i` falls after a preemption, `cfg_policy_i` decides what happens next. 2'b00 resumes with the sum and count kept. 2'b01 restarts with both cleared. 2'b10 and 2'b11 stop: the channel goes idle with `done_o` left at 0.
- R9: A trigger that arrives while the channel is busy has no effect on the burst, its length or its sum.
- R10: After reset, `busy_o`, `done_o`, `intr_o`, `conv_req_o` and `sum_o` are all 0.
- R11: While idle, `sum_o` and `done_o` hold their values. The next trigger clears both at the edge that takes it in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start a burst (used only while idle) |
| hp_pend_i | input | 1 | Higher-priority conversion request pending |
| irq_clr_i | input | 1 | Clear the interrupted flag |
| cfg_count_i | input | 4 | Conversions per burst minus one |
| cfg_force_stop_i | input | 1 | Allow a pending request to cancel a running conversion |
| cfg_no_intra_i | input | 1 | In non-forced mode, forbid preemption between samples |
| cfg_policy_i | input | 2 | Action after preemption: 00 resume, 01 restart, 1x stop |
| conv_req_o | output | 1 | Sample request to the conversion engine (level) |
| conv_ack_i | input | 1 | One-cycle sample-valid pulse from the engine |
| conv_data_i | input | 12 | Sample value, valid with `conv_ack_i` |
| busy_o | output | 1 | Burst in progress or paused |
| done_o | output | 1 | Burst completed; cleared by the next trigger |
| intr_o | output | 1 | Sticky preemption flag |
| sum_o | output | 16 | Accumulated result |

## Verification
The bench builds the block with its default widths: 12-bit samples, a 16-bit sum and a 4-bit count. The engine stub answers four cycles after each request. These widths let the bench sweep all sixteen burst lengths, once with varied samples and once with every sample at full scale, so the 65520 ceiling of the sum is reached. Each preemption mode and each policy code is exercised, with the expected sum computed from the stub's own sample sequence.

// File: rtl/mcacc_pkg.sv
package mcacc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_PAUSE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        POL_RESUME  = 2'b00,
        POL_RESTART = 2'b01,
        POL_STOP_A  = 2'b10,
        POL_STOP_B  = 2'b11
    } after_pol_e;
endpackage

// File: rtl/mcacc_preempt.sv
module mcacc_preempt (
    input  logic in_conv_i,
    input  logic ack_i,
    input  logic last_i,
    input  logic hp_pend_i,
    input  logic force_stop_i,
    input  logic no_intra_i,
    output logic yield_o,
    output logic abort_o
);
    logic gap_allowed;

    always_comb begin
        gap_allowed = force_stop_i | ~no_intra_i;
        yield_o     = in_conv_i & ack_i & ~last_i & hp_pend_i & gap_allowed;
        abort_o     = in_conv_i & ~ack_i & hp_pend_i & force_stop_i;
    end
endmodule

// File: rtl/mcacc_accum.sv
module mcacc_accum #(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 16,
    parameter int CNTR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                add_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SUM_W-1:0]    sum_o,
    output logic [CNTR_W-1:0]   taken_o
);
    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [CNTR_W-1:0] taken;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d.sum   = '0;
            acc_d.taken = '0;
        end else if (add_i) begin
            acc_d.sum   = acc_q.sum + SUM_W'(sample_i);
            acc_d.taken = acc_q.taken + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum_o   = acc_q.sum;
    assign taken_o = acc_q.taken;
endmodule

// File: rtl/mcacc_seq.sv
module mcacc_seq
    import mcacc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 16,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_i,
    input  logic                hp_pend_i,
    input  logic                irq_clr_i,
    input  logic [CNT_W-1:0]    cfg_count_i,
    input  logic                cfg_force_stop_i,
    input  logic                cfg_no_intra_i,
    input  logic [1:0]          cfg_policy_i,
    output logic                conv_req_o,
    input  logic                conv_ack_i,
    input  logic [SAMPLE_W-1:0] conv_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                intr_o,
    output logic [SUM_W-1:0]    sum_o
);
    localparam int CNTR_W = CNT_W + 1;

    typedef struct packed {
        seq_state_e st;
        logic       req;
        logic       done;
        logic       intr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              acc_clr, acc_add;
    logic [CNTR_W-1:0] taken;
    logic              last_smp, yield_now, abort_now, in_conv;

    assign in_conv  = (ctl_q.st == ST_CONV);
    assign last_smp = conv_ack_i && (taken == CNTR_W'(cfg_count_i));

    mcacc_preempt u_preempt (
        .in_conv_i    (in_conv),
        .ack_i        (conv_ack_i),
        .last_i       (last_smp),
        .hp_pend_i    (hp_pend_i),
        .force_stop_i (cfg_force_stop_i),
        .no_intra_i   (cfg_no_intra_i),
        .yield_o      (yield_now),
        .abort_o      (abort_now)
    );

    mcacc_accum #(
        .SAMPLE_W (SAMPLE_W),
        .SUM_W    (SUM_W),
        .CNTR_W   (CNTR_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (acc_clr),
        .add_i    (acc_add),
        .sample_i (conv_data_i),
        .sum_o    (sum_o),
        .taken_o  (taken)
    );

    always_comb begin
        ctl_d   = ctl_q;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        if (irq_clr_i) ctl_d.intr = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    ctl_d.st   = ST_CONV;
                    ctl_d.req  = 1'b1;
                    ctl_d.done = 1'b0;
                    acc_clr    = 1'b1;
                end
            end
            ST_CONV: begin
                acc_add = conv_ack_i;
                if (last_smp) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.req  = 1'b0;
                    ctl_d.done = 1'b1;
                end else if (yield_now || abort_now) begin
                    ctl_d.st   = ST_PAUSE;
                    ctl_d.req  = 1'b0;
                    ctl_d.intr = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (!hp_pend_i) begin
                    case (after_pol_e'(cfg_policy_i))
                        POL_RESUME: begin
                            ctl_d.st  = ST_CONV;
                            ctl_d.req = 1'b1;
                        end
                        POL_RESTART: begin
                            ctl_d.st  = ST_CONV;
                            ctl_d.req = 1'b1;
                            acc_clr   = 1'b1;
                        end
                        default: begin
                            ctl_d.st  = ST_IDLE;
                            ctl_d.req = 1'b0;
                        end
                    endcase
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.req  <= 1'b0;
            ctl_q.done <= 1'b0;
            ctl_q.intr <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign conv_req_o = ctl_q.req;
    assign busy_o     = (ctl_q.st != ST_IDLE);
    assign done_o     = ctl_q.done;
    assign intr_o     = ctl_q.intr;
endmodule

// File: rtl/mcacc_seq_chk.sv
module mcacc_seq_chk #(
    parameter int SUM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_i,
    input logic             hp_pend_i,
    input logic             irq_clr_i,
    input logic             cfg_force_stop_i,
    input logic             conv_req_o,
    input logic             conv_ack_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             intr_o,
    input logic [SUM_W-1:0] sum_o
);
    // R3: completion is reported only once the channel has left its burst
    a_r3_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o);

    // R4/R5: without forced stop, an open conversion is never withdrawn
    a_r5_no_midconv_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_ack_i && !cfg_force_stop_i) |=> conv_req_o);

    // R6: forced stop withdraws the request at once and flags it
    a_r6_forced_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_ack_i && hp_pend_i && cfg_force_stop_i) |=> (!conv_req_o && intr_o));

    // R7: the interrupted flag is sticky until cleared
    a_r7_intr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && !irq_clr_i) |=> intr_o);

    // R9: the sum moves only on an accepted sample while converting
    a_r9_sum_hold_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_ack_i) |=> $stable(sum_o));

    // R11: idle without a trigger keeps result and completion
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !trig_i) |=> ($stable(sum_o) && $stable(done_o)));
endmodule

bind mcacc_seq mcacc_seq_chk #(.SUM_W(SUM_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .trig_i           (trig_i),
    .hp_pend_i        (hp_pend_i),
    .irq_clr_i        (irq_clr_i),
    .cfg_force_stop_i (cfg_force_stop_i),
    .conv_req_o       (conv_req_o),
    .conv_ack_i       (conv_ack_i),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .intr_o           (intr_o),
    .sum_o            (sum_o)
);

// File: tb/mcacc_seq_tb_top.sv
`timescale 1ns/1ps
module mcacc_seq_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0, hp = 1'b0, iclr = 1'b0;
    logic [3:0]  cnt_cfg = '0;
    logic        fstop = 1'b0, nointra = 1'b0;
    logic [1:0]  pol = 2'b00;
    logic        req, ack = 1'b0;
    logic [11:0] data = '0;
    logic        busy, done, intr;
    logic [15:0] sum;

    int total = 0, bad = 0;
    int k = 0;
    int pat = 0;
    int stub_cnt = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    mcacc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .hp_pend_i(hp), .irq_clr_i(iclr),
        .cfg_count_i(cnt_cfg), .cfg_force_stop_i(fstop), .cfg_no_intra_i(nointra),
        .cfg_policy_i(pol), .conv_req_o(req), .conv_ack_i(ack), .conv_data_i(data),
        .busy_o(busy), .done_o(done), .intr_o(intr), .sum_o(sum)
    );

    function automatic int val(int idx);
        if (pat == 1) return 4095;
        return (idx * 2731 + 977) % 4096;
    endfunction

    function automatic int sum_vals(int a, int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += val(a + i);
        return s;
    endfunction

    // conversion engine stub: fixed latency, cancelled when the request drops
    always @(posedge clk) begin
        if (!req) begin
            stub_cnt <= 0;
            ack      <= 1'b0;
        end else if (stub_cnt == LAT - 1) begin
            stub_cnt <= 0;
            ack      <= 1'b1;
            data     <= 12'(val(k));
            k        <= k + 1;
        end else begin
            stub_cnt <= stub_cnt + 1;
            ack      <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_k(input int target);
        for (int i = 0; i < 1000 && k < target; i++) @(negedge clk);
    endtask

    task automatic clear_intr();
        @(negedge clk) iclr = 1'b1;
        @(negedge clk) iclr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k0, kr, s0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy && !done && !intr && !req && sum == 0, "R10 reset", {busy, done, intr, req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: sweep every burst length with two sample patterns
        for (int p = 0; p < 2; p++) begin
            pat = p;
            for (int n = 0; n < 16; n++) begin
                @(negedge clk) cnt_cfg = 4'(n);
                k0 = k;
                pulse_trig();
                wait_idle();
                check(done == 1'b1, n == 0 ? "R2 done" : "R1 done", done, 1);
                check(k - k0 == n + 1, n == 0 ? "R2 count" : "R1 count", k - k0, n + 1);
                check(sum == 16'(sum_vals(k0, n + 1)), "R3 sum", sum, sum_vals(k0, n + 1));
            end
        end
        pat = 0;

        // R11: hold while idle, then cleared by the next trigger
        s0 = sum;
        repeat (8) @(negedge clk);
        check(sum == 16'(s0) && done, "R11 hold", sum, s0);
        cnt_cfg = 4'd2;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        check(sum == 0 && !done && busy, "R11 clear", sum, 0);
        wait_idle();

        // R9: trigger during a burst is ignored
        @(negedge clk) cnt_cfg = 4'd5;
        k0 = k;
        pulse_trig();
        repeat (6) @(negedge clk);
        pulse_trig();
        wait_idle();
        check(k - k0 == 6, "R9 count", k - k0, 6);
        check(sum == 16'(sum_vals(k0, 6)), "R9 sum", sum, sum_vals(k0, 6));

        // R4: non-forced, not interruptible
        @(negedge clk) begin cnt_cfg = 4'd3; fstop = 1'b0; nointra = 1'b1; pol = 2'b00; end
        k0 = k;
        pulse_trig();
        hp = 1'b1;
        wait_idle();
        hp = 1'b0;
        check(done && k - k0 == 4, "R4 runs through", k - k0, 4);
        check(!intr, "R4 no flag", intr, 0);
        check(sum == 16'(sum_vals(k0, 4)), "R4 sum", sum, sum_vals(k0, 4));

        // R5: non-forced, interruptible only between samples
        @(negedge clk) nointra = 1'b0;
        k0 = k;
        pulse_trig();
        hp = 1'b1;
        wait_k(k0 + 1);
        @(negedge clk);
        check(!req && busy && intr, "R5 yield at gap", {req, busy, intr}, 3);
        repeat (10) @(negedge clk);
        check(k == k0 + 1 && !req, "R5 held", k - k0, 1);
        hp = 1'b0;
        wait_idle();
        check(done && k - k0 == 4, "R8 resume count", k - k0, 4);
        check(sum == 16'(sum_vals(k0, 4)), "R8 resume sum", sum, sum_vals(k0, 4));

        // R7: clear, then sticky behaviour
        clear_intr();
        check(!intr, "R7 clear", intr, 0);

        // R6: forced stop cancels the running conversion
        @(negedge clk) fstop = 1'b1;
        k0 = k;
        pulse_trig();
        hp = 1'b1;
        @(negedge clk);
        check(!req && intr && k == k0, "R6 abort", k - k0, 0);
        repeat (5) @(negedge clk);
        check(intr, "R7 sticky", intr, 1);
        hp = 1'b0;
        wait_idle();
        check(done && k - k0 == 4, "R6 discarded not counted", k - k0, 4);
        check(sum == 16'(sum_vals(k0, 4)), "R6 sum", sum, sum_vals(k0, 4));

        // R7: set wins over a simultaneous clear
        clear_intr();
        k0 = k;
        pulse_trig();
        hp = 1'b1;
        iclr = 1'b1;
        @(negedge clk);
        iclr = 1'b0;
        check(intr, "R7 set wins", intr, 1);
        hp = 1'b0;
        wait_idle();

        // R8: restart clears sum and count
        @(negedge clk) pol = 2'b01;
        k0 = k;
        pulse_trig();
        wait_k(k0 + 2);
        @(negedge clk) hp = 1'b1;
        repeat (4) @(negedge clk);
        kr = k;
        hp = 1'b0;
        wait_idle();
        check(done && k - kr == 4, "R8 restart count", k - kr, 4);
        check(sum == 16'(sum_vals(kr, 4)), "R8 restart sum", sum, sum_vals(kr, 4));

        // R8: both stop codes abandon the burst
        for (int c = 2; c < 4; c++) begin
            @(negedge clk) begin pol = 2'(c); cnt_cfg = 4'd7; end
            k0 = k;
            pulse_trig();
            wait_k(k0 + 1);
            @(negedge clk) hp = 1'b1;
            repeat (3) @(negedge clk);
            hp = 1'b0;
            repeat (2) @(negedge clk);
            kr = k;
            check(!busy && !done, "R8 stop idle", {busy, done}, 0);
            repeat (10) @(negedge clk);
            check(k == kr && !req, "R8 stop no more", k - kr, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule